// File: doc/BRIEF.md
# Quick DMA Channel Trigger and Completion Control

This block holds the control state for eight quick DMA channels. Each channel is pointed at one parameter slot and at one 32-bit word inside that slot. Software starts a transfer by writing to that word through the ordinary register bus, not by writing a start register. When the written address matches a channel's mapping and that channel's event is enabled, the block raises a one-cycle event request toward the transfer engine.

Each channel also keeps two flags. The first marks an event that has been issued and not yet acknowledged. The second records a trigger that arrived while the first flag was still set. Software clears both flags by writing ones to their clear registers.

On the return side, the transfer engine reports a 6-bit completion code with a strobe. The code sets one bit of a 64-bit pending vector, which is read as a low half and a high half. Each half has its own write-1-to-clear register. The interrupt output is high while any pending bit is set. Software polls a pending bit and then clears it.

Top module: `qdma_trig_ctrl`

## Requirements
- R1: After reset, all channel maps read 0, all enable, outstanding and missed flags read 0, both pending halves read 0, `evt_req` is 0 and `irq` is 0.
- R2: The map register of channel n is at byte offset 0x0100 + 4n. Bits [13:5] hold the slot number and bits [4:2] hold the word index. All other bits read back as 0.
- R3: Writing the enable-set register (0x0200) turns on the enable of every channel whose data bit is 1. Writing the enable-clear register (0x0204) turns those enables off. Bits written as 0 change nothing. The enables read back at 0x0208, with bit n for channel n.
- R4: A write to byte address 0x4000 + 32·slot + 4·word that matches an enabled channel's map, while that channel's outstanding flag is clear, drives `evt_req[n]` high for exactly the one cycle after the write. It also sets the outstanding flag, which reads back at 0x0214 as bit n.
- R5: A write to any other word of the slot, to any other slot, or to the mapped word of a disabled channel issues no request. It also leaves the outstanding and missed flags unchanged.
- R6: A matching trigger on an enabled channel whose outstanding flag is already set issues no request. Instead it sets the missed flag, which reads back at 0x021C as bit n.
- R7: Writing 1 to bit n of the outstanding-clear register (0x0210) clears that channel's outstanding flag. Writing 1 to bit n of the missed-clear register (0x0218) clears its missed flag. Bits written as 0 have no effect.
- R8: A completion strobe with a code c below 32 sets bit c of the low pending half (0x0300). A code of 32 to 63 sets bit c−32 of the high pending half (0x0304). The bit is visible on the cycle after the strobe.
- R9: Writing 1s to the low clear register (0x0308) or the high clear register (0x030C) clears those pending bits of that half only. Bits written as 0 have no effect.
- R10: A completion and a clear that hit the same pending bit in the same cycle leave the bit set.
- R11: `irq` is high exactly while at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 16 | Byte address of the read |
| rd_data | output | 32 | Read data (combinational from rd_addr) |
| cmp_valid | input | 1 | Completion strobe from the transfer engine |
| cmp_code | input | 6 | Completion code |
| evt_req | output | 8 | One-cycle event request, one bit per channel |
| irq | output | 1 | Completion interrupt |

## Verification
The bound checker watches the properties that hold on every cycle.

For requests, it checks that each request is a single-cycle pulse. A request always comes with the outstanding flag set and the channel enabled, and it never follows a cycle in which that flag was already set. A newly set missed flag never appears together with a request.

For completions, it checks that every completion strobe leaves its pending bit and `irq` set on the next cycle.

The bench scenarios show the rest:
- the address decode, by sweeping every word of every mapped slot, the neighbouring slots, and the map register field layout;
- the set and clear registers, with their zero-bit behaviour;
- the full sweep of all 64 completion codes across both halves;
- a clear that collides with a completion in the same cycle.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
  localparam int QD_NUM_CH = 8;
  localparam int QD_SLOT_W = 9;
  localparam int QD_WORD_W = 3;
  localparam int QD_CODE_W = 6;
  localparam int QD_AW     = 16;
  localparam int QD_DW     = 32;

  localparam logic [QD_AW-1:0] OFS_MAP_BASE  = 16'h0100;
  localparam logic [QD_AW-1:0] OFS_EN_SET    = 16'h0200;
  localparam logic [QD_AW-1:0] OFS_EN_CLR    = 16'h0204;
  localparam logic [QD_AW-1:0] OFS_EN_STAT   = 16'h0208;
  localparam logic [QD_AW-1:0] OFS_SEC_CLR   = 16'h0210;
  localparam logic [QD_AW-1:0] OFS_SEC_STAT  = 16'h0214;
  localparam logic [QD_AW-1:0] OFS_MISS_CLR  = 16'h0218;
  localparam logic [QD_AW-1:0] OFS_MISS_STAT = 16'h021C;
  localparam logic [QD_AW-1:0] OFS_PEND_LO   = 16'h0300;
  localparam logic [QD_AW-1:0] OFS_PEND_HI   = 16'h0304;
  localparam logic [QD_AW-1:0] OFS_PCLR_LO   = 16'h0308;
  localparam logic [QD_AW-1:0] OFS_PCLR_HI   = 16'h030C;
  localparam logic [QD_AW-1:0] OFS_SLOT_BASE = 16'h4000;
endpackage

// File: rtl/qdma_dec.sv
module qdma_dec
  import qdma_pkg::*;
#(
  parameter int NUM_CH = QD_NUM_CH,
  parameter int SLOT_W = QD_SLOT_W,
  parameter int WORD_W = QD_WORD_W,
  parameter int AW     = QD_AW
) (
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  output logic [NUM_CH-1:0] map_we,
  output logic              en_set_we,
  output logic              en_clr_we,
  output logic              sec_clr_we,
  output logic              miss_clr_we,
  output logic              pclr_lo_we,
  output logic              pclr_hi_we,
  output logic              trig_we,
  output logic [SLOT_W-1:0] trig_slot,
  output logic [WORD_W-1:0] trig_word
);
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SLOT_LSB = WORD_W + 2;
  localparam int SLOT_TOP = SLOT_LSB + SLOT_W;

  logic map_hit;

  assign map_hit = wr_en && (wr_addr[AW-1:CH_W+2] == OFS_MAP_BASE[AW-1:CH_W+2]);

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_map_we
    assign map_we[gi] = map_hit && (wr_addr[CH_W+1:2] == CH_W'(gi));
  end

  assign en_set_we   = wr_en && (wr_addr == OFS_EN_SET);
  assign en_clr_we   = wr_en && (wr_addr == OFS_EN_CLR);
  assign sec_clr_we  = wr_en && (wr_addr == OFS_SEC_CLR);
  assign miss_clr_we = wr_en && (wr_addr == OFS_MISS_CLR);
  assign pclr_lo_we  = wr_en && (wr_addr == OFS_PCLR_LO);
  assign pclr_hi_we  = wr_en && (wr_addr == OFS_PCLR_HI);

  // Parameter slot window: slot and word come straight from the address.
  assign trig_we   = wr_en && (wr_addr[AW-1:SLOT_TOP] == OFS_SLOT_BASE[AW-1:SLOT_TOP]);
  assign trig_slot = wr_addr[SLOT_TOP-1:SLOT_LSB];
  assign trig_word = wr_addr[SLOT_LSB-1:2];
endmodule

// File: rtl/qdma_chan.sv
module qdma_chan
  import qdma_pkg::*;
#(
  parameter int SLOT_W = QD_SLOT_W,
  parameter int WORD_W = QD_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_we,
  input  logic [SLOT_W-1:0] map_slot_d,
  input  logic [WORD_W-1:0] map_word_d,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              sec_clr,
  input  logic              miss_clr,
  input  logic              trig_we,
  input  logic [SLOT_W-1:0] trig_slot,
  input  logic [WORD_W-1:0] trig_word,
  output logic [SLOT_W-1:0] map_slot_q,
  output logic [WORD_W-1:0] map_word_q,
  output logic              en_q,
  output logic              sec_q,
  output logic              miss_q,
  output logic              req_q
);
  logic hit, fire, lost;
  logic en_d, sec_d, miss_d;

  always_comb begin
    hit    = trig_we && en_q && (trig_slot == map_slot_q) && (trig_word == map_word_q);
    fire   = hit && !sec_q;
    lost   = hit && sec_q;
    en_d   = en_set ? 1'b1 : (en_clr ? 1'b0 : en_q);
    sec_d  = fire ? 1'b1 : (sec_clr ? 1'b0 : sec_q);
    miss_d = lost ? 1'b1 : (miss_clr ? 1'b0 : miss_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_slot_q <= '0;
      map_word_q <= '0;
    end else if (map_we) begin
      map_slot_q <= map_slot_d;
      map_word_q <= map_word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sec_q  <= 1'b0;
      miss_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      sec_q  <= sec_d;
      miss_q <= miss_d;
      req_q  <= fire;
    end
  end
endmodule

// File: rtl/qdma_pend.sv
module qdma_pend
  import qdma_pkg::*;
#(
  parameter int CODE_W = QD_CODE_W,
  localparam int PEND_W = 1 << CODE_W,
  localparam int HALF_W = PEND_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [CODE_W-1:0] cmp_code,
  input  logic              clr_lo_we,
  input  logic              clr_hi_we,
  input  logic [HALF_W-1:0] clr_bits,
  output logic [PEND_W-1:0] pend_q,
  output logic              irq
);
  logic [PEND_W-1:0] set_vec, clr_vec, pend_d;

  always_comb begin
    set_vec = cmp_valid ? (PEND_W'(1) << cmp_code) : '0;
    clr_vec = {(clr_hi_we ? clr_bits : '0), (clr_lo_we ? clr_bits : '0)};
    pend_d  = (pend_q & ~clr_vec) | set_vec;  // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign irq = |pend_q;
endmodule

// File: rtl/qdma_trig_ctrl.sv
module qdma_trig_ctrl
  import qdma_pkg::*;
#(
  parameter int NUM_CH = QD_NUM_CH,
  parameter int SLOT_W = QD_SLOT_W,
  parameter int WORD_W = QD_WORD_W,
  parameter int CODE_W = QD_CODE_W,
  parameter int AW     = QD_AW,
  parameter int DW     = QD_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              cmp_valid,
  input  logic [CODE_W-1:0] cmp_code,
  output logic [NUM_CH-1:0] evt_req,
  output logic              irq
);
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int PEND_W   = 1 << CODE_W;
  localparam int HALF_W   = PEND_W / 2;
  localparam int SLOT_LSB = WORD_W + 2;

  logic [NUM_CH-1:0]             map_we;
  logic                          en_set_we, en_clr_we, sec_clr_we, miss_clr_we;
  logic                          pclr_lo_we, pclr_hi_we, trig_we;
  logic [SLOT_W-1:0]             trig_slot;
  logic [WORD_W-1:0]             trig_word;
  logic [NUM_CH-1:0][SLOT_W-1:0] map_slot;
  logic [NUM_CH-1:0][WORD_W-1:0] map_word;
  logic [NUM_CH-1:0]             en_vec, sec_vec, miss_vec;
  logic [PEND_W-1:0]             pend_vec;
  logic [CH_W-1:0]               rd_idx;

  qdma_dec #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .WORD_W(WORD_W), .AW(AW)) u_dec (
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .map_we     (map_we),
    .en_set_we  (en_set_we),
    .en_clr_we  (en_clr_we),
    .sec_clr_we (sec_clr_we),
    .miss_clr_we(miss_clr_we),
    .pclr_lo_we (pclr_lo_we),
    .pclr_hi_we (pclr_hi_we),
    .trig_we    (trig_we),
    .trig_slot  (trig_slot),
    .trig_word  (trig_word)
  );

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chan
    qdma_chan #(.SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .map_we    (map_we[gc]),
      .map_slot_d(wr_data[SLOT_LSB+SLOT_W-1:SLOT_LSB]),
      .map_word_d(wr_data[SLOT_LSB-1:2]),
      .en_set    (en_set_we && wr_data[gc]),
      .en_clr    (en_clr_we && wr_data[gc]),
      .sec_clr   (sec_clr_we && wr_data[gc]),
      .miss_clr  (miss_clr_we && wr_data[gc]),
      .trig_we   (trig_we),
      .trig_slot (trig_slot),
      .trig_word (trig_word),
      .map_slot_q(map_slot[gc]),
      .map_word_q(map_word[gc]),
      .en_q      (en_vec[gc]),
      .sec_q     (sec_vec[gc]),
      .miss_q    (miss_vec[gc]),
      .req_q     (evt_req[gc])
    );
  end

  qdma_pend #(.CODE_W(CODE_W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_valid(cmp_valid),
    .cmp_code (cmp_code),
    .clr_lo_we(pclr_lo_we),
    .clr_hi_we(pclr_hi_we),
    .clr_bits (wr_data[HALF_W-1:0]),
    .pend_q   (pend_vec),
    .irq      (irq)
  );

  assign rd_idx = rd_addr[CH_W+1:2];

  always_comb begin
    rd_data = '0;
    if (rd_addr[AW-1:CH_W+2] == OFS_MAP_BASE[AW-1:CH_W+2]) begin
      rd_data = DW'({map_slot[rd_idx], map_word[rd_idx], 2'b00});
    end else begin
      case (rd_addr)
        OFS_EN_STAT:   rd_data = DW'(en_vec);
        OFS_SEC_STAT:  rd_data = DW'(sec_vec);
        OFS_MISS_STAT: rd_data = DW'(miss_vec);
        OFS_PEND_LO:   rd_data = DW'(pend_vec[HALF_W-1:0]);
        OFS_PEND_HI:   rd_data = DW'(pend_vec[PEND_W-1:HALF_W]);
        default:       rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/qdma_trig_ctrl_chk.sv
module qdma_trig_ctrl_chk #(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 6,
  localparam int PEND_W = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] evt_req,
  input logic [NUM_CH-1:0] en_vec,
  input logic [NUM_CH-1:0] sec_vec,
  input logic [NUM_CH-1:0] miss_vec,
  input logic              cmp_valid,
  input logic [CODE_W-1:0] cmp_code,
  input logic [PEND_W-1:0] pend_vec,
  input logic              irq
);
  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_req & $past(evt_req)) == '0);  // R4
  AST_REQ_MARKS_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_req & ~sec_vec) == '0);  // R4
  AST_REQ_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_req & ~en_vec) == '0);  // R5
  AST_REQ_NOT_WHILE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_req & $past(sec_vec)) == '0);  // R6
  AST_MISS_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((miss_vec & ~$past(miss_vec)) & evt_req) == '0);  // R6
  AST_CMP_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> pend_vec[$past(cmp_code)]);  // R10
  AST_CMP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> irq);  // R11
endmodule

bind qdma_trig_ctrl qdma_trig_ctrl_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_req  (evt_req),
  .en_vec   (en_vec),
  .sec_vec  (sec_vec),
  .miss_vec (miss_vec),
  .cmp_valid(cmp_valid),
  .cmp_code (cmp_code),
  .pend_vec (pend_vec),
  .irq      (irq)
);

// File: tb/qdma_trig_ctrl_tb.sv
`timescale 1ns/1ps
module qdma_trig_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        cmp_valid = 1'b0;
  logic [5:0]  cmp_code = '0;
  logic [7:0]  evt_req;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  qdma_trig_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmp_valid(cmp_valid), .cmp_code(cmp_code),
    .evt_req(evt_req), .irq(irq)
  );

  function automatic int slot_of(input int ch);
    return (ch * 61 + 3) % 512;
  endfunction
  function automatic int word_of(input int ch);
    return (ch * 5 + 1) % 8;
  endfunction
  function automatic logic [15:0] taddr(input int slot, input int word);
    return 16'(16'h4000 + slot * 32 + word * 4);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic complete(input logic [5:0] c);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_code = c;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "evt_req", 32'(evt_req), 32'h0);
    chk("R1", "irq", 32'(irq), 32'h0);
    bus_rd(16'h0208, v); chk("R1", "enables", v, 32'h0);
    bus_rd(16'h0214, v); chk("R1", "outstanding", v, 32'h0);
    bus_rd(16'h021C, v); chk("R1", "missed", v, 32'h0);
    bus_rd(16'h0300, v); chk("R1", "pend lo", v, 32'h0);
    bus_rd(16'h0304, v); chk("R1", "pend hi", v, 32'h0);
    for (int ch = 0; ch < 8; ch++) begin
      bus_rd(16'(16'h0100 + ch * 4), v); chk("R1", "map", v, 32'h0);
    end

    // R2 map field layout and programming
    bus_wr(16'h0100, 32'hFFFF_FFFF);
    bus_rd(16'h0100, v); chk("R2", "map all ones", v, 32'h0000_3FFC);
    for (int ch = 0; ch < 8; ch++)
      bus_wr(16'(16'h0100 + ch * 4), 32'((slot_of(ch) << 5) | (word_of(ch) << 2)));
    for (int ch = 0; ch < 8; ch++) begin
      bus_rd(16'(16'h0100 + ch * 4), v);
      chk("R2", "map readback", v, 32'((slot_of(ch) << 5) | (word_of(ch) << 2)));
    end

    // R3 enable set/clear
    bus_wr(16'h0200, 32'h05); bus_rd(16'h0208, v); chk("R3", "set 05", v, 32'h05);
    bus_wr(16'h0200, 32'h02); bus_rd(16'h0208, v); chk("R3", "set 02", v, 32'h07);
    bus_wr(16'h0204, 32'h01); bus_rd(16'h0208, v); chk("R3", "clr 01", v, 32'h06);
    bus_wr(16'h0204, 32'h00); bus_rd(16'h0208, v); chk("R3", "clr 00", v, 32'h06);
    bus_wr(16'h0200, 32'hFF); bus_rd(16'h0208, v); chk("R3", "set ff", v, 32'hFF);

    // R4 / R5 sweep over every word of each mapped slot, plus neighbour slot
    for (int ch = 0; ch < 8; ch++) begin
      for (int w = 0; w < 8; w++) begin
        bus_wr(taddr(slot_of(ch), w), 32'hA5A5_0000 + 32'(w));
        chk(w == word_of(ch) ? "R4" : "R5", "sweep req", 32'(evt_req),
            w == word_of(ch) ? 32'(1 << ch) : 32'h0);
      end
      @(negedge clk);
      chk("R4", "pulse ends", 32'(evt_req), 32'h0);
      bus_rd(16'h0214, v); chk("R4", "outstanding", v, 32'(1 << ch));
      bus_wr(16'h0210, 32'(1 << ch));
      bus_rd(16'h0214, v); chk("R7", "outstanding cleared", v, 32'h0);
      bus_wr(taddr(slot_of(ch) + 1, word_of(ch)), 32'h0);
      chk("R5", "neighbour slot", 32'(evt_req), 32'h0);
    end
    bus_rd(16'h021C, v); chk("R5", "no misses after sweep", v, 32'h0);

    // R5 disabled channel
    bus_wr(16'h0204, 32'h04);
    bus_wr(taddr(slot_of(2), word_of(2)), 32'h1);
    chk("R5", "disabled req", 32'(evt_req), 32'h0);
    bus_rd(16'h0214, v); chk("R5", "disabled outstanding", v, 32'h0);
    bus_rd(16'h021C, v); chk("R5", "disabled missed", v, 32'h0);
    bus_wr(16'h0200, 32'h04);

    // R6 / R7 missed event and flag clears
    bus_wr(taddr(slot_of(3), word_of(3)), 32'h1);
    chk("R4", "first trigger", 32'(evt_req), 32'h08);
    bus_wr(taddr(slot_of(3), word_of(3)), 32'h2);
    chk("R6", "second trigger req", 32'(evt_req), 32'h0);
    bus_rd(16'h021C, v); chk("R6", "missed set", v, 32'h08);
    bus_rd(16'h0214, v); chk("R6", "outstanding kept", v, 32'h08);
    bus_wr(16'h0218, 32'h08); bus_rd(16'h021C, v); chk("R7", "missed cleared", v, 32'h0);
    bus_wr(16'h0210, 32'h00); bus_rd(16'h0214, v); chk("R7", "zero clear", v, 32'h08);
    bus_wr(16'h0210, 32'h08); bus_rd(16'h0214, v); chk("R7", "outstanding clr", v, 32'h0);

    // R8 / R11 sweep over all completion codes
    for (int c = 0; c < 64; c++) begin
      complete(6'(c));
      bus_rd(16'h0300, v); chk("R8", "pend lo", v, c < 32 ? 32'(1 << c) : 32'h0);
      bus_rd(16'h0304, v); chk("R8", "pend hi", v, c >= 32 ? 32'(1 << (c - 32)) : 32'h0);
      chk("R11", "irq high", 32'(irq), 32'h1);
      bus_wr(c < 32 ? 16'h0308 : 16'h030C, 32'(1 << (c % 32)));
      bus_rd(16'h0300, v); chk("R9", "lo cleared", v, 32'h0);
      bus_rd(16'h0304, v); chk("R9", "hi cleared", v, 32'h0);
      chk("R11", "irq low", 32'(irq), 32'h0);
    end

    // R9 per-half clears, zero bits ignored
    complete(6'd3); complete(6'd40);
    bus_wr(16'h0308, 32'h0);
    bus_rd(16'h0300, v); chk("R9", "zero clear lo", v, 32'h08);
    bus_wr(16'h030C, 32'h100);
    bus_rd(16'h0304, v); chk("R9", "hi bit8 cleared", v, 32'h0);
    bus_rd(16'h0300, v); chk("R9", "lo untouched", v, 32'h08);
    chk("R11", "irq from lo", 32'(irq), 32'h1);
    bus_wr(16'h0308, 32'h08);
    chk("R11", "irq clear", 32'(irq), 32'h0);

    // R10 completion and clear on the same bit in the same cycle
    @(negedge clk);
    cmp_valid = 1'b1; cmp_code = 6'd5;
    wr_en = 1'b1; wr_addr = 16'h0308; wr_data = 32'h20;
    @(negedge clk);
    cmp_valid = 1'b0; wr_en = 1'b0;
    bus_rd(16'h0300, v); chk("R10", "set wins", v, 32'h20);
    chk("R10", "irq", 32'(irq), 32'h1);
    bus_wr(16'h0308, 32'h20);
    bus_rd(16'h0300, v); chk("R9", "final clear", v, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule